// File: doc/BRIEF.md
# SRAM Instruction-Fetch Permission Gate

This block sits in front of an on-chip SRAM and decides, for each access, whether an instruction fetch may reach the array. Its decision draws on three sources. The first is a redundant byte from the one-time-programmable hardware configuration that enables fetching. The second is a lifecycle signal that says whether debug functions are enabled. The third is a software execute-enable register that can be locked. Data accesses always pass through. A fetch that is refused is answered in the same cycle with an error flag and zeroed read data, and it never reaches the memory.

All booleans use an 8-bit redundant code in which only one exact pattern means "true". When the programmed enable is true, the software register alone decides, and the lifecycle debug state has no influence. When the programmed enable is false, the debug state decides on its own, whatever the register holds. A build parameter turns fetching off for good on instances that must never execute code, such as a retention memory.

Top module: `sram_fetch_gate`

## Requirements
- R1: After reset, the execute register (register index 0, byte in bits [7:0]) reads 0xA5 and the lock register (register index 1, bit 0) reads 0.
- R2: When the programmed enable byte is 0x5A, a fetch is granted exactly when the execute register holds 0x5A. The debug input has no effect in this case.
- R3: When the programmed enable byte is not 0x5A and the debug input is 0x5A, every fetch is granted, whatever the execute register holds.
- R4: When the programmed enable byte is not 0x5A and the debug input is not 0x5A, every fetch is refused.
- R5: Each 8-bit boolean (programmed byte, debug input, execute register) counts as true only at exactly 0x5A. Any other value, including 0xA5, counts as false.
- R6: Bits [31:8] of the configuration word have no effect on any decision. Only bits [7:0] carry the enable byte.
- R7: Writing a 1 to bit 0 of the lock register sets the lock. Writing 0 leaves it unchanged, and once set it stays set until reset. While it is set, writes to the execute register are ignored.
- R8: A refused fetch gets a response in the same cycle as the request, with the error flag high, read data zero and no memory request.
- R9: Data accesses (attribute low) are always forwarded to memory and answered without error, returning the memory read data.
- R10: A write accepted into the execute register changes the fetch decision from the next cycle on. The request in the same cycle as the write still sees the old value.
- R11: With the fetch-disable parameter set, every fetch is refused whatever the inputs, while data accesses still pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| otpCfgWord_i | input | 32 | Configuration word; enable byte in [7:0] |
| debugEn_i | input | 8 | Lifecycle debug-enabled, 8-bit redundant boolean |
| regWe_i | input | 1 | Register write strobe |
| regAddr_i | input | RegAddrW | Register index |
| regWdata_i | input | 32 | Register write data |
| regRdata_o | output | 32 | Register read data (combinational) |
| reqValid_i | input | 1 | Access request valid |
| reqIsFetch_i | input | 1 | 1 = instruction fetch, 0 = data |
| memRdata_i | input | DataW | Read data from the SRAM |
| memReq_o | output | 1 | Request forwarded to the SRAM |
| respValid_o | output | 1 | Response valid |
| respErr_o | output | 1 | Response error (refused fetch) |
| respRdata_o | output | DataW | Response read data |

## Verification
The assertions check on every cycle that the lock only ever rises and freezes the execute register, that an accepted execute write appears in the register one cycle later, that a refused fetch carries zero data and no memory request, that data accesses never report an error, and that a fetch-disabled instance never grants a fetch. The bench scenarios are needed to show the three-way priority among the programmed byte, the debug state and the register. They also cover the fail-safe decoding of non-canonical byte values, the indifference to the upper configuration bits, and the one-cycle delay between a register write and the decision.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  localparam logic [7:0] MuBiTrue  = 8'h5A;
  localparam logic [7:0] MuBiFalse = 8'hA5;
  localparam int unsigned ExecIdx = 0;
  localparam int unsigned LockIdx = 1;

  typedef struct packed {
    logic       execOn;
    logic       lockOn;
    logic [7:0] execByte;
  } ctrlStrobes_t;

  function automatic logic mubiIsTrue(logic [7:0] v);
    return v == MuBiTrue;
  endfunction
endpackage

// File: rtl/sfg_regs.sv
module sfg_regs
  import sfg_pkg::*;
#(
  parameter int unsigned RegAddrW = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                regWe_i,
  input  logic [RegAddrW-1:0] regAddr_i,
  input  logic [31:0]         regWdata_i,
  output logic [31:0]         regRdata_o,
  output ctrlStrobes_t        ctrl_o
);
  logic [7:0] execReg;
  logic       lockReg;
  logic       execWrite;
  logic       lockWrite;
  logic       unusedWdataHigh;

  assign execWrite = regWe_i && (regAddr_i == RegAddrW'(ExecIdx)) && !lockReg;
  assign lockWrite = regWe_i && (regAddr_i == RegAddrW'(LockIdx)) && regWdata_i[0];
  assign unusedWdataHigh = ^regWdata_i[31:8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      execReg <= MuBiFalse;
      lockReg <= 1'b0;
    end else begin
      if (execWrite) execReg <= regWdata_i[7:0];
      if (lockWrite) lockReg <= 1'b1;
    end
  end

  always_comb begin
    regRdata_o = '0;
    if (regAddr_i == RegAddrW'(ExecIdx))      regRdata_o = {24'h0, execReg};
    else if (regAddr_i == RegAddrW'(LockIdx)) regRdata_o = {31'h0, lockReg};
  end

  assign ctrl_o.execOn   = mubiIsTrue(execReg);
  assign ctrl_o.lockOn   = lockReg;
  assign ctrl_o.execByte = execReg;

  // R7: lock never drops once set
  a_r7_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockReg |=> lockReg);
  // R7: locked register ignores writes
  a_r7_exec_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lockReg && regWe_i) |=> $stable(execReg));
  // R10: accepted write visible one cycle later
  a_r10_write_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regWe_i && regAddr_i == RegAddrW'(ExecIdx) && !lockReg)
      |=> execReg == $past(regWdata_i[7:0]));
endmodule

// File: rtl/sfg_gate.sv
module sfg_gate
  import sfg_pkg::*;
#(
  parameter int unsigned DataW        = 32,
  parameter bit          FetchDisable = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ctrlStrobes_t       ctrl_i,
  input  logic [31:0]        otpCfgWord_i,
  input  logic [7:0]         debugEn_i,
  input  logic               reqValid_i,
  input  logic               reqIsFetch_i,
  input  logic [DataW-1:0]   memRdata_i,
  output logic               memReq_o,
  output logic               respValid_o,
  output logic               respErr_o,
  output logic [DataW-1:0]   respRdata_o
);
  logic fetchOk;
  logic denied;
  logic unusedInputs;

  generate
    if (FetchDisable) begin : g_off
      assign fetchOk = 1'b0;
      assign unusedInputs = ^{otpCfgWord_i, debugEn_i, ctrl_i};
    end else begin : g_on
      logic otpOn;
      logic dbgOn;
      assign otpOn = mubiIsTrue(otpCfgWord_i[7:0]);
      assign dbgOn = mubiIsTrue(debugEn_i);
      // programmed enable hands control to the register; debug is only fallback
      assign fetchOk = otpOn ? ctrl_i.execOn : dbgOn;
      assign unusedInputs = ^{otpCfgWord_i[31:8], ctrl_i.lockOn, ctrl_i.execByte};
    end
  endgenerate

  assign denied      = reqValid_i && reqIsFetch_i && !fetchOk;
  assign memReq_o    = reqValid_i && !denied;
  assign respValid_o = reqValid_i;
  assign respErr_o   = denied;
  assign respRdata_o = denied ? '0 : memRdata_i;

  // R8: refused fetch never reaches memory and returns zero
  a_r8_deny_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (respValid_o && respErr_o) |-> (respRdata_o == '0 && !memReq_o));
  // R9: data accesses never flagged
  a_r9_data_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reqValid_i && !reqIsFetch_i) |-> (memReq_o && !respErr_o));
  // R11: disabled instance grants no fetch
  a_r11_never_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (FetchDisable && reqValid_i && reqIsFetch_i) |-> (respErr_o && !memReq_o));
endmodule

// File: rtl/sram_fetch_gate.sv
module sram_fetch_gate
  import sfg_pkg::*;
#(
  parameter int unsigned DataW        = 32,
  parameter int unsigned RegAddrW     = 2,
  parameter bit          FetchDisable = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [31:0]         otpCfgWord_i,
  input  logic [7:0]          debugEn_i,
  input  logic                regWe_i,
  input  logic [RegAddrW-1:0] regAddr_i,
  input  logic [31:0]         regWdata_i,
  output logic [31:0]         regRdata_o,
  input  logic                reqValid_i,
  input  logic                reqIsFetch_i,
  input  logic [DataW-1:0]    memRdata_i,
  output logic                memReq_o,
  output logic                respValid_o,
  output logic                respErr_o,
  output logic [DataW-1:0]    respRdata_o
);
  ctrlStrobes_t ctrl;

  sfg_regs #(.RegAddrW(RegAddrW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .regWe_i(regWe_i), .regAddr_i(regAddr_i),
    .regWdata_i(regWdata_i), .regRdata_o(regRdata_o), .ctrl_o(ctrl)
  );

  sfg_gate #(.DataW(DataW), .FetchDisable(FetchDisable)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl), .otpCfgWord_i(otpCfgWord_i),
    .debugEn_i(debugEn_i), .reqValid_i(reqValid_i), .reqIsFetch_i(reqIsFetch_i),
    .memRdata_i(memRdata_i), .memReq_o(memReq_o), .respValid_o(respValid_o),
    .respErr_o(respErr_o), .respRdata_o(respRdata_o)
  );
endmodule

// File: tb/tb_sram_fetch_gate.sv
module tb_sram_fetch_gate;
  localparam int ClkPeriod = 10;
  localparam int DataW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] otpWord = '0;
  logic [7:0]  dbg = 8'hA5;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        reqValid = 1'b0;
  logic        reqFetch = 1'b0;
  logic [DataW-1:0] memRdata = '0;
  logic [31:0] rdA, rdB;
  logic memReqA, validA, errA, memReqB, validB, errB;
  logic [DataW-1:0] respA, respB;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] mExec = 8'hA5;
  logic       mLock = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  sram_fetch_gate #(.DataW(DataW), .RegAddrW(2), .FetchDisable(1'b0)) dut (
    .clk_i(clk), .rst_ni(rstN), .otpCfgWord_i(otpWord), .debugEn_i(dbg),
    .regWe_i(we), .regAddr_i(addr), .regWdata_i(wdata), .regRdata_o(rdA),
    .reqValid_i(reqValid), .reqIsFetch_i(reqFetch), .memRdata_i(memRdata),
    .memReq_o(memReqA), .respValid_o(validA), .respErr_o(errA), .respRdata_o(respA));

  sram_fetch_gate #(.DataW(DataW), .RegAddrW(2), .FetchDisable(1'b1)) dutOff (
    .clk_i(clk), .rst_ni(rstN), .otpCfgWord_i(otpWord), .debugEn_i(dbg),
    .regWe_i(we), .regAddr_i(addr), .regWdata_i(wdata), .regRdata_o(rdB),
    .reqValid_i(reqValid), .reqIsFetch_i(reqFetch), .memRdata_i(memRdata),
    .memReq_o(memReqB), .respValid_o(validB), .respErr_o(errB), .respRdata_o(respB));

  function automatic bit expOk(logic [7:0] otp8, logic [7:0] d8, logic [7:0] ex8);
    if (otp8 == 8'h5A) return ex8 == 8'h5A;
    return d8 == 8'h5A;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // check one access on both instances; inputs already settled
  task automatic checkAccess(string req);
    bit ok;
    ok = !reqFetch || expOk(otpWord[7:0], dbg, mExec);
    chk(memReqA == ok && errA == !ok && validA, req, {memReqA, errA}, {ok, !ok});
    chk(respA == (ok ? memRdata : '0), "R8", respA, ok ? memRdata : '0);
    chk(errB == reqFetch && memReqB == !reqFetch && respB == (reqFetch ? '0 : memRdata),
        "R11", {errB, memReqB}, {reqFetch, !reqFetch});
  endtask

  task automatic regWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    if (a == 2'd0 && !mLock) mExec = d[7:0];
    if (a == 2'd1 && d[0]) mLock = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [7:0] pickByte(int sel);
    case (sel % 4)
      0: return 8'h5A;
      1: return 8'hA5;
      2: return 8'h5A ^ (8'h1 << (sel % 8));
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #(ClkPeriod * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5FA7_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    addr = 2'd0; #1; chk(rdA == 32'hA5, "R1", rdA, 32'hA5);
    addr = 2'd1; #1; chk(rdA == 32'h0, "R1", rdA, 32'h0);

    // directed priority table, R2 / R3 / R4
    reqValid = 1'b1; reqFetch = 1'b1; memRdata = 32'hCAFE_0001;
    otpWord = 32'h0000_005A; dbg = 8'h5A; #1; checkAccess("R2");
    chk(errA == 1'b1, "R2", errA, 1'b1);
    otpWord = 32'h0000_00A5; #1; checkAccess("R3");
    chk(errA == 1'b0, "R3", errA, 1'b0);
    dbg = 8'hA5; #1; checkAccess("R4");
    chk(errA == 1'b1, "R4", errA, 1'b1);

    // R10: write takes effect next cycle
    otpWord = 32'h0000_005A;
    @(negedge clk);
    we = 1'b1; addr = 2'd0; wdata = 32'h5A; #1;
    chk(errA == 1'b1, "R10", errA, 1'b1);
    @(posedge clk); #1;
    mExec = 8'h5A;
    chk(errA == 1'b0, "R10", errA, 1'b0);
    @(negedge clk); we = 1'b0;

    // R6: upper bytes ignored, R5: near-miss values false
    otpWord = 32'hA5A5_A55A; #1; checkAccess("R6");
    chk(errA == 1'b0, "R6", errA, 1'b0);
    otpWord = 32'h5A5A_5A5B; dbg = 8'h5A; #1; checkAccess("R5");
    otpWord = 32'h0000_0000; dbg = 8'h5B; #1; checkAccess("R5");
    chk(errA == 1'b1, "R5", errA, 1'b1);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      if (($urandom % 8) == 0) regWrite(2'd0, {24'($urandom), pickByte(int'($urandom % 64))});
      @(negedge clk);
      otpWord = {24'($urandom), pickByte(int'($urandom % 64))};
      dbg = pickByte(int'($urandom % 64));
      reqValid = 1'b1;
      reqFetch = 1'($urandom);
      memRdata = DataW'($urandom);
      #1;
      checkAccess(reqFetch ? "R2" : "R9");
      if (!reqFetch) chk(respA == memRdata && !errA, "R9", respA, memRdata);
    end

    // R7: lock behaviour
    regWrite(2'd0, 32'h5A);
    regWrite(2'd1, 32'h0);
    addr = 2'd1; #1; chk(rdA == 32'h0, "R7", rdA, 32'h0);
    regWrite(2'd1, 32'h1);
    addr = 2'd1; #1; chk(rdA == 32'h1, "R7", rdA, 32'h1);
    regWrite(2'd0, 32'hA5);
    addr = 2'd0; #1; chk(rdA == 32'h5A, "R7", rdA, 32'h5A);
    otpWord = 32'h5A; dbg = 8'hA5; reqFetch = 1'b1; #1; checkAccess("R7");
    chk(errA == 1'b0, "R7", errA, 1'b0);
    regWrite(2'd1, 32'h0);
    addr = 2'd1; #1; chk(rdA == 32'h1, "R7", rdA, 32'h1);

    // reset clears lock (R1)
    @(negedge clk); rstN = 1'b0; mExec = 8'hA5; mLock = 1'b0;
    @(negedge clk); rstN = 1'b1; #1;
    addr = 2'd1; #1; chk(rdA == 32'h0, "R1", rdA, 32'h0);
    addr = 2'd0; #1; chk(rdA == 32'hA5, "R1", rdA, 32'hA5);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule